// File: doc/BRIEF.md
# ADC Acquisition and Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. When software pulses the start input, the block raises its busy output. It may first wait through an automatic acquisition interval. It then resolves the result one bit per conversion-clock period, most significant bit first. To do this it presents a trial code to an external DAC and keeps or drops each trial bit according to a one-bit comparator input. When the conversion ends, busy drops, a sticky completion flag rises and the result register is loaded.

The conversion clock is either the system clock divided by a power of two, chosen through a 3-bit code whose encoding is not monotonic, or one-cycle ticks from an external slow oscillator. The clock code and the acquisition code are captured when the start pulse is accepted. Changing these inputs during a run therefore does not affect that run. No output tells the acquisition phase apart from the conversion phase.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A start pulse sampled while idle makes busy_o read 1 after that clock edge.
- R2: A conversion lasts exactly RES_W+1 conversion-clock periods. The first is a setup period that clears the approximation register. Each later period resolves one bit, MSB first.
- R3: Clock codes 000, 100, 001, 101, 010 and 110 divide the system clock by 2, 4, 8, 16, 32 and 64 respectively. Each period is that many system cycles.
- R4: Clock codes 011 and 111 count one conversion-clock period per system cycle in which osc_tick_i is 1 while busy.
- R5: With acquisition code 000, conversion begins at once, so busy lasts (RES_W+1) periods.
- R6: Acquisition codes 001 to 111 insert 2, 4, 6, 8, 12, 16 and 20 periods respectively before conversion, so busy lasts (acq+RES_W+1) periods.
- R7: At completion busy_o clears, flag_o sets and result_o takes the resolved code. The comparator input is 1 when the analog input is at or above trial_o, so the result equals the analog code.
- R8: result_o changes only at completion and is stable while busy.
- R9: flag_o stays 1 until clr_flag_i is asserted; a clear while idle drops it on the next edge.
- R10: Start pulses while busy are ignored and do not change the run's length or result.
- R11: Clock and acquisition code changes while busy take effect only at the next start.
- R12: After reset busy_o, flag_o and result_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request (accepted only while idle) |
| clr_flag_i | input | 1 | Clears the completion flag |
| clk_sel_i | input | 3 | Conversion-clock select code |
| acq_sel_i | input | 3 | Acquisition-time code, 000 = none |
| osc_tick_i | input | 1 | External slow-oscillator tick |
| cmp_i | input | 1 | Comparator: 1 when input is at or above trial_o |
| trial_o | output | RES_W | Trial code for the DAC, 0 outside bit periods |
| busy_o | output | 1 | Busy during acquisition and conversion |
| flag_o | output | 1 | Sticky completion flag |
| result_o | output | RES_W | Last conversion result |

## Verification
The bench builds the block at its default 10-bit width. At that width the largest run (20 acquisition periods at divide-by-64) stays under 2000 cycles. This makes it possible to sweep all 48 internal clock/acquisition code pairs, each with a different target code including 0 and 1023, and to check the busy length cycle for cycle. Both external-tick codes are run with hand-driven ticks. Dedicated runs disturb a conversion with a second start and changed codes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2
    } seq_st_e;

    // Codes with low bits 11 pick the external tick source.
    function automatic logic sel_is_ext(input logic [SEL_W-1:0] c);
        return (c[1:0] == 2'b11);
    endfunction

    // Shift applied to 2: low two bits carry the major step, bit 2 the minor.
    function automatic logic [2:0] sel_shift(input logic [SEL_W-1:0] c);
        return {c[1:0], c[2]};
    endfunction

    function automatic logic [4:0] acq_periods(input logic [SEL_W-1:0] c);
        logic [4:0] n;
        case (c)
            3'd0:    n = 5'd0;
            3'd1:    n = 5'd2;
            3'd2:    n = 5'd4;
            3'd3:    n = 5'd6;
            3'd4:    n = 5'd8;
            3'd5:    n = 5'd12;
            3'd6:    n = 5'd16;
            default: n = 5'd20;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
    import adc_seq_pkg::*;
#(
    parameter int SHIFT_MAX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             ext_tick_i,
    output logic             tick_o
);
    localparam int CNT_W = SHIFT_MAX + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] term;
    logic             ext;

    always_comb begin
        ext   = sel_is_ext(sel_i);
        term  = CNT_W'((32'd2 << sel_shift(sel_i)) - 32'd1);
        cnt_d = cnt_q;
        if (!run_i || ext) begin
            cnt_d = '0;
        end else if (cnt_q == term) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
        tick_o = run_i && (ext ? ext_tick_i : (cnt_q == term));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
    parameter int RES_W = 10,
    localparam int IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [IDX_W-1:0] bit_idx_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] next_o
);
    logic [RES_W-1:0] code_d, code_q;

    always_comb begin
        trial_o = code_q | (RES_W'(1) << bit_idx_i);
        next_o  = cmp_i ? trial_o : code_q;
        code_d  = code_q;
        if (clear_i)     code_d = '0;
        else if (step_i) code_d = next_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int SHIFT_MAX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             clr_flag_i,
    input  logic [2:0]       clk_sel_i,
    input  logic [2:0]       acq_sel_i,
    input  logic             osc_tick_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o,
    output logic             busy_o,
    output logic             flag_o,
    output logic [RES_W-1:0] result_o
);
    localparam int ACQ_MAX = 20;
    localparam int PER_MAX = (RES_W > ACQ_MAX) ? RES_W : ACQ_MAX;
    localparam int PER_W   = $clog2(PER_MAX + 1);
    localparam int IDX_W   = $clog2(RES_W);

    typedef struct packed {
        seq_st_e          st;
        logic [PER_W-1:0] per;
        logic [SEL_W-1:0] clk_sel;
        logic [SEL_W-1:0] acq_sel;
        logic             flag;
        logic [RES_W-1:0] result;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic             tick;
    logic             run;
    logic             sar_clear;
    logic             sar_step;
    logic             bit_phase;
    logic [IDX_W-1:0] bit_idx;
    logic [RES_W-1:0] sar_trial;
    logic [RES_W-1:0] sar_next;
    logic [4:0]       acq_n;

    assign run = (s_q.st != ST_IDLE);

    adc_tick_gen #(.SHIFT_MAX(SHIFT_MAX)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .sel_i      (s_q.clk_sel),
        .ext_tick_i (osc_tick_i),
        .tick_o     (tick)
    );

    adc_sar_reg #(.RES_W(RES_W)) u_sar (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (sar_clear),
        .step_i    (sar_step),
        .bit_idx_i (bit_idx),
        .cmp_i     (cmp_i),
        .trial_o   (sar_trial),
        .next_o    (sar_next)
    );

    always_comb begin
        s_d       = s_q;
        acq_n     = acq_periods(s_q.acq_sel);
        bit_phase = (s_q.st == ST_CONV) && (s_q.per != '0);
        bit_idx   = bit_phase ? IDX_W'(RES_W - int'(s_q.per)) : '0;
        sar_clear = (s_q.st == ST_CONV) && (s_q.per == '0);
        sar_step  = bit_phase && tick;

        if (clr_flag_i) s_d.flag = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.clk_sel = clk_sel_i;
                    s_d.acq_sel = acq_sel_i;
                    s_d.per     = '0;
                    s_d.st      = (acq_sel_i == '0) ? ST_CONV : ST_ACQ;
                end
            end
            ST_ACQ: begin
                if (tick) begin
                    if (s_q.per == PER_W'(acq_n - 5'd1)) begin
                        s_d.st  = ST_CONV;
                        s_d.per = '0;
                    end else begin
                        s_d.per = s_q.per + 1'b1;
                    end
                end
            end
            ST_CONV: begin
                if (tick) begin
                    if (s_q.per == PER_W'(RES_W)) begin
                        s_d.st     = ST_IDLE;
                        s_d.per    = '0;
                        s_d.flag   = 1'b1;
                        s_d.result = sar_next;
                    end else begin
                        s_d.per = s_q.per + 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, per: '0, clk_sel: '0, acq_sel: '0,
                     flag: 1'b0, result: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign trial_o  = bit_phase ? sar_trial : '0;
    assign busy_o   = run;
    assign flag_o   = s_q.flag;
    assign result_o = s_q.result;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             clr_flag_i,
    input logic             busy_o,
    input logic             flag_o,
    input logic [RES_W-1:0] result_o
);
    AST_IDLE_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o); // R1

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> flag_o); // R7

    AST_RESULT_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(result_o)); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_flag_i) |=> flag_o); // R9

    AST_FLAG_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag_i && !busy_o) |=> !flag_o); // R9

    AST_IDLE_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> $stable(result_o)); // R8

endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .clr_flag_i (clr_flag_i),
    .busy_o     (busy_o),
    .flag_o     (flag_o),
    .result_o   (result_o)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int RES_W      = 10;
    localparam int CONV_P     = RES_W + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             clr_flag_i = 1'b0;
    logic [2:0]       clk_sel_i = 3'd0;
    logic [2:0]       acq_sel_i = 3'd0;
    logic             osc_tick_i = 1'b0;
    logic             cmp_i;
    logic [RES_W-1:0] trial_o;
    logic             busy_o;
    logic             flag_o;
    logic [RES_W-1:0] result_o;
    logic [RES_W-1:0] target = '0;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Comparator model: analog input at or above the trial code.
    assign cmp_i = (target >= trial_o);

    adc_seq_ctrl #(.RES_W(RES_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .clr_flag_i(clr_flag_i),
        .clk_sel_i(clk_sel_i), .acq_sel_i(acq_sel_i), .osc_tick_i(osc_tick_i),
        .cmp_i(cmp_i), .trial_o(trial_o), .busy_o(busy_o), .flag_o(flag_o),
        .result_o(result_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int divisor(input logic [2:0] c);
        int idx;
        idx = int'(c[1:0]) * 2 + int'(c[2]);
        return 2 << idx;
    endfunction

    function automatic int acq_len(input logic [2:0] c);
        int t[8] = '{0, 2, 4, 6, 8, 12, 16, 20};
        return t[c];
    endfunction

    // Internal-clock run; disturb adds a mid-run start and code change.
    task automatic run_int(input logic [2:0] cs, input logic [2:0] as,
                           input int tgt, input bit disturb, input string req);
        int n;
        int exp_n;
        logic [RES_W-1:0] old_res;
        bit res_moved;
        @(negedge clk);
        target    = RES_W'(tgt);
        clk_sel_i = cs;
        acq_sel_i = as;
        start_i   = 1'b1;
        old_res   = result_o;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R1", int'(busy_o), 1);
        exp_n = (acq_len(as) + CONV_P) * divisor(cs);
        n = 0;
        res_moved = 1'b0;
        while (busy_o && n < 5000) begin
            if (result_o != old_res) res_moved = 1'b1;
            n++;
            if (disturb && n == 3) begin
                start_i   = 1'b1;
                clk_sel_i = 3'b110;
                acq_sel_i = 3'b111;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(n == exp_n, req, n, exp_n);
        chk(!res_moved, "R8", int'(res_moved), 0);
        chk(result_o == RES_W'(tgt), "R7", int'(result_o), tgt);
        chk(flag_o == 1'b1, "R7", int'(flag_o), 1);
    endtask

    task automatic run_ext(input logic [2:0] cs, input logic [2:0] as, input int tgt);
        int k;
        int exp_k;
        @(negedge clk);
        target    = RES_W'(tgt);
        clk_sel_i = cs;
        acq_sel_i = as;
        start_i   = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy_o == 1'b1, "R4", int'(busy_o), 1);
        exp_k = acq_len(as) + CONV_P;
        k = 0;
        while (busy_o && k < 100) begin
            osc_tick_i = 1'b1;
            @(negedge clk);
            osc_tick_i = 1'b0;
            k++;
            @(negedge clk);
            @(negedge clk);
        end
        chk(k == exp_k, "R4", k, exp_k);
        chk(result_o == RES_W'(tgt), "R7", int'(result_o), tgt);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        clr_flag_i = 1'b1;
        @(negedge clk);
        clr_flag_i = 1'b0;
        chk(flag_o == 1'b0, "R9", int'(flag_o), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(busy_o == 1'b0, "R12", int'(busy_o), 0);
        chk(flag_o == 1'b0, "R12", int'(flag_o), 0);
        chk(result_o == '0, "R12", int'(result_o), 0);

        // R5 immediate conversion, extreme codes
        run_int(3'b000, 3'b000, 1023, 1'b0, "R5");
        clear_flag();
        run_int(3'b000, 3'b000, 0, 1'b0, "R2");
        // R9 flag held without clear
        repeat (6) @(negedge clk);
        chk(flag_o == 1'b1, "R9", int'(flag_o), 1);
        clear_flag();

        // R3/R6 sweep over every internal clock code and acquisition code
        for (int ci = 0; ci < 8; ci++) begin
            for (int ai = 0; ai < 8; ai++) begin
                logic [2:0] cs;
                int tg;
                cs = 3'(ci);
                if (cs[1:0] != 2'b11) begin
                    tg = (ci * 8 + ai) * 389 % 1024;
                    if (ci == 6 && ai == 7) tg = 1023;
                    run_int(cs, 3'(ai), tg, 1'b0, (ai == 0) ? "R3" : "R6");
                    if ((ci + ai) % 2 == 0) clear_flag();
                end
            end
        end
        clear_flag();

        // R10 + R11: second start and code changes during a run
        run_int(3'b100, 3'b001, 613, 1'b1, "R10");
        clear_flag();
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R10", int'(busy_o), 0);
        // R11: the changed codes apply to the next start
        run_int(3'b110, 3'b111, 341, 1'b0, "R11");
        clear_flag();

        // R4 external tick codes
        run_ext(3'b011, 3'b000, 682);
        clear_flag();
        run_ext(3'b111, 3'b010, 5);
        clear_flag();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule